// File: doc/BRIEF.md
# Timer Trigger and Interrupt Controller

This block sits beside a pulse-pattern timer channel and decides when the channel is started and when it raises an interrupt. It watches an external trigger pin through a synchronizer and reports a rising edge, a falling edge, either edge or nothing, depending on a two-bit edge mode. A software trigger bit in the control register starts the channel in any edge mode, including the one that ignores the pin. The qualified trigger leaves the block as a one-cycle pulse that the counter uses to start.

The counter and duty comparator live outside and send one-cycle strobes for counter borrow and for duty match. A two-bit source field picks which events may set the pending flag: the trigger, borrow, duty match, or borrow and duty match together. The flag is a two-state machine, `FLAG_IDLE` and `FLAG_PENDING`. The transition `IDLE -> PENDING` ("raise") happens when interrupts are enabled and a selected event arrives. The transition `PENDING -> IDLE` ("retire") happens on a CPU write of 0 to the flag bit or on a DMA clear strobe, unless a raise happens in the same cycle. When no event or clear arrives, each state holds ("hold"). The pin tracker is a second two-state machine, `LVL_LOW` and `LVL_HIGH`. It follows the synchronized pin level with the transitions "go high" and "go low", and the edge mode decides which of these counts as a trigger.

The CPU reads and writes one 8-bit control register: bit 0 software trigger, bits 2:1 edge mode, bit 3 interrupt enable, bit 4 pending flag, bits 6:5 source select, bit 7 unused. A read flagged as the read half of a read-modify-write returns 1 in the flag bit, so the write-back that follows cannot clear the flag.

Top module: `tmr_trig_irq`

## Requirements
- R1: After reset, `cpu_rdata` reads 0x00 (edge mode 00, source 00, enable 0, flag 0), and `trig_out`, `irq_req` and `dma_req` are 0.
- R2: With edge mode 01, a low-to-high change on `trig_in` produces one `trig_out` pulse, and a high-to-low change produces none.
- R3: With edge mode 10, only a high-to-low change gives a pulse. With mode 11, both changes give a pulse. With mode 00, the pin never gives a pulse.
- R4: Writing 1 to bit 0 gives exactly one `trig_out` pulse, in the cycle after the write, in every edge mode. Bit 0 always reads 0.
- R5: Source select in bits 6:5 sets which events may set the flag: 00 trigger, 01 borrow, 10 duty match, 11 borrow or duty match. Any other event leaves the flag unchanged.
- R6: While enable (bit 3) is 0, no event sets the flag.
- R7: A register write with bit 4 = 0, or a `dma_clr` pulse, clears the flag. A write with bit 4 = 1 leaves the flag unchanged.
- R8: If a set event and a clear arrive in the same cycle, the flag is 1 afterwards.
- R9: While `cpu_rd_en` and `cpu_rmw` are both 1, `cpu_rdata` bit 4 reads 1 whatever the flag holds. Otherwise bit 4 shows the flag.
- R10: `irq_req` equals flag AND enable. `dma_req` equals flag AND `dma_en`.
- R11: A change on `trig_in` seen at clock edge n shows on `trig_out` in the cycle after edge n+1. The flag it sets is visible after edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_in | input | 1 | External trigger pin, asynchronous |
| cpu_wr_en | input | 1 | Control register write strobe |
| cpu_rd_en | input | 1 | Control register read strobe |
| cpu_rmw | input | 1 | Marks the read as part of a read-modify-write |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data |
| borrow_evt | input | 1 | Counter borrow strobe, one cycle |
| duty_evt | input | 1 | Duty match strobe, one cycle |
| dma_en | input | 1 | Allows the DMA start request |
| dma_clr | input | 1 | Flag clear strobe from the DMA controller |
| trig_out | output | 1 | Qualified trigger pulse to the counter |
| irq_req | output | 1 | Interrupt request to the CPU |
| dma_req | output | 1 | DMA transfer start request |

## Verification
A flag machine stuck in the wrong state shows up one cycle after a set event or clear, on `irq_req`, `dma_req` and bit 4 of `cpu_rdata`. A clear that wrongly wins over a set shows up the same way. A pin tracker that falls out of step with the synchronized level sends a pulse at the wrong time, or misses one, in the cycle after the second synchronizer edge, and `trig_out` shows it directly. A software trigger bit that fails to self-clear shows as a `trig_out` pulse longer than one cycle.

// File: rtl/tti_pkg.sv
package tti_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        SRC_TRIG   = 2'b00,
        SRC_BORROW = 2'b01,
        SRC_DUTY   = 2'b10,
        SRC_EITHER = 2'b11
    } irq_src_e;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

    localparam int BIT_SW   = 0;
    localparam int BIT_EDGE = 1;
    localparam int BIT_IEN  = 3;
    localparam int BIT_FLAG = 4;
    localparam int BIT_SRC  = 5;
endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det
    import tti_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_in,
    input  edge_mode_e mode,
    output logic       hit
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         level;
    lvl_state_e   state_q;
    logic         go_high;
    logic         go_low;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= trig_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[TOP-1:0], trig_in};
            end
        end
    endgenerate

    assign level = sync_q[TOP];

    // state register: follows the synchronized level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= level ? LVL_HIGH : LVL_LOW;
    end

    // outputs: transitions qualified by the edge mode
    always_comb begin
        go_high = (state_q == LVL_LOW)  &&  level;
        go_low  = (state_q == LVL_HIGH) && !level;
        unique case (mode)
            EDGE_OFF:  hit = 1'b0;
            EDGE_RISE: hit = go_high;
            EDGE_FALL: hit = go_low;
            EDGE_BOTH: hit = go_high | go_low;
            default:   hit = 1'b0;
        endcase
    end

    // R3: a reported edge always moves the tracker to the other level
    assert_hit_moves_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (state_q != $past(state_q)));
endmodule

// File: rtl/irq_flag_fsm.sv
module irq_flag_fsm
    import tti_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     trig_evt,
    input  logic     borrow_evt,
    input  logic     duty_evt,
    input  irq_src_e src,
    input  logic     ien,
    input  logic     clr_req,
    input  logic     dma_en,
    output logic     flag,
    output logic     irq_req,
    output logic     dma_req
);
    flag_state_e state_q;
    flag_state_e state_d;
    logic        src_hit;
    logic        set_evt;

    always_comb begin
        unique case (src)
            SRC_TRIG:   src_hit = trig_evt;
            SRC_BORROW: src_hit = borrow_evt;
            SRC_DUTY:   src_hit = duty_evt;
            SRC_EITHER: src_hit = borrow_evt | duty_evt;
            default:    src_hit = 1'b0;
        endcase
        set_evt = ien & src_hit;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:    if (set_evt)              state_d = FLAG_PENDING;
            FLAG_PENDING: if (clr_req && !set_evt)  state_d = FLAG_IDLE;
            default:                                state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag    = (state_q == FLAG_PENDING);
        irq_req = flag & ien;
        dma_req = flag & dma_en;
    end

    // R8: a set event wins against a clear in the same cycle
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> (state_q == FLAG_PENDING));
    // R7: a lone clear retires the flag
    assert_clear_retires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_evt) |=> (state_q == FLAG_IDLE));
    // R6: with interrupts disabled an idle flag stays idle
    assert_no_raise_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien && state_q == FLAG_IDLE) |=> (state_q == FLAG_IDLE));
endmodule

// File: rtl/tmr_trig_irq.sv
module tmr_trig_irq
    import tti_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REG_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic             cpu_wr_en,
    input  logic             cpu_rd_en,
    input  logic             cpu_rmw,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             borrow_evt,
    input  logic             duty_evt,
    input  logic             dma_en,
    input  logic             dma_clr,
    output logic             trig_out,
    output logic             irq_req,
    output logic             dma_req
);
    localparam int USED_W = BIT_SRC + 2;

    edge_mode_e edge_q;
    irq_src_e   src_q;
    logic       ien_q;
    logic       sw_q;
    logic       edge_hit;
    logic       trig_evt;
    logic       clr_req;
    logic       flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= EDGE_OFF;
            src_q  <= SRC_TRIG;
            ien_q  <= 1'b0;
            sw_q   <= 1'b0;
        end else if (cpu_wr_en) begin
            edge_q <= edge_mode_e'(cpu_wdata[BIT_EDGE +: 2]);
            src_q  <= irq_src_e'(cpu_wdata[BIT_SRC +: 2]);
            ien_q  <= cpu_wdata[BIT_IEN];
            sw_q   <= cpu_wdata[BIT_SW];
        end else begin
            sw_q   <= 1'b0;
        end
    end

    assign clr_req  = (cpu_wr_en && !cpu_wdata[BIT_FLAG]) || dma_clr;
    assign trig_evt = sw_q | edge_hit;
    assign trig_out = trig_evt;

    always_comb begin
        cpu_rdata                = '0;
        cpu_rdata[BIT_EDGE +: 2] = edge_q;
        cpu_rdata[BIT_IEN]       = ien_q;
        cpu_rdata[BIT_FLAG]      = flag | (cpu_rd_en & cpu_rmw);
        cpu_rdata[BIT_SRC +: 2]  = src_q;
    end

    trig_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .mode    (edge_q),
        .hit     (edge_hit)
    );

    irq_flag_fsm u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_evt   (trig_evt),
        .borrow_evt (borrow_evt),
        .duty_evt   (duty_evt),
        .src        (src_q),
        .ien        (ien_q),
        .clr_req    (clr_req),
        .dma_en     (dma_en),
        .flag       (flag),
        .irq_req    (irq_req),
        .dma_req    (dma_req)
    );

    initial begin
        assert (USED_W <= REG_W) else $error("register too narrow");
    end

    // R4: the software trigger lasts one cycle unless written again
    assert_sw_self_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_q && !cpu_wr_en) |=> !sw_q);
    // R10: an interrupt request implies the CPU sees a pending flag
    assert_irq_has_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !cpu_rd_en) |-> cpu_rdata[BIT_FLAG]);
endmodule

// File: tb/test_tmr_trig_irq.sv
module test_tmr_trig_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_in = 1'b0;
    logic       cpu_wr_en = 1'b0;
    logic       cpu_rd_en = 1'b0;
    logic       cpu_rmw = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       borrow_evt = 1'b0;
    logic       duty_evt = 1'b0;
    logic       dma_en = 1'b0;
    logic       dma_clr = 1'b0;
    logic       trig_out;
    logic       irq_req;
    logic       dma_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_trig_irq i_tmr_trig_irq (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en), .cpu_rmw(cpu_rmw),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .borrow_evt(borrow_evt), .duty_evt(duty_evt),
        .dma_en(dma_en), .dma_clr(dma_clr),
        .trig_out(trig_out), .irq_req(irq_req), .dma_req(dma_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // register write: {0, src, flagbit, ien, edge, sw}; returns at the negedge after the write
    task automatic wr(input logic [1:0] em, input logic ien, input logic [1:0] src,
                      input logic fb, input logic sw);
        @(negedge clk);
        cpu_wr_en = 1'b1;
        cpu_wdata = {1'b0, src, fb, ien, em, sw};
        @(negedge clk);
        cpu_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rdata", cpu_rdata, 8'h00);
        check("R1 trig_out", {7'd0, trig_out}, 8'd0);
        check("R1 irq_req", {7'd0, irq_req}, 8'd0);
        check("R1 dma_req", {7'd0, dma_req}, 8'd0);
    endtask

    task automatic t_sw();
        wr(2'b00, 1'b1, 2'b00, 1'b1, 1'b1);
        check("R4 pulse", {7'd0, trig_out}, 8'd1);
        check("R4 bit0 reads 0", {7'd0, cpu_rdata[0]}, 8'd0);
        @(negedge clk);
        check("R4 single cycle", {7'd0, trig_out}, 8'd0);
        check("R4 sets flag in mode 00", {7'd0, irq_req}, 8'd1);
        wr(2'b00, 1'b1, 2'b00, 1'b0, 1'b0);
        check("R7 write 0 clears", {7'd0, cpu_rdata[4]}, 8'd0);
    endtask

    task automatic t_edge(input logic [1:0] em, input logic lvl, input logic exp, input string req);
        wr(em, 1'b1, 2'b00, 1'b0, 1'b0);
        trig_in = lvl;
        @(negedge clk);
        check({req, " R11 no early pulse"}, {7'd0, trig_out}, 8'd0);
        @(negedge clk);
        check({req, " R11 pulse"}, {7'd0, trig_out}, {7'd0, exp});
        @(negedge clk);
        check({req, " R11 pulse ends"}, {7'd0, trig_out}, 8'd0);
        check({req, " R11 flag"}, {7'd0, cpu_rdata[4]}, {7'd0, exp});
    endtask

    task automatic t_evt(input logic [1:0] src, input logic b, input logic d,
                         input logic exp, input string req);
        wr(2'b00, 1'b1, src, 1'b0, 1'b0);
        borrow_evt = b;
        duty_evt = d;
        @(negedge clk);
        borrow_evt = 1'b0;
        duty_evt = 1'b0;
        check(req, {7'd0, cpu_rdata[4]}, {7'd0, exp});
    endtask

    task automatic t_disabled();
        wr(2'b00, 1'b0, 2'b00, 1'b0, 1'b1);
        @(negedge clk);
        check("R6 sw trigger no flag", {7'd0, cpu_rdata[4]}, 8'd0);
        wr(2'b00, 1'b0, 2'b01, 1'b0, 1'b0);
        borrow_evt = 1'b1;
        @(negedge clk);
        borrow_evt = 1'b0;
        check("R6 borrow no flag", {7'd0, cpu_rdata[4]}, 8'd0);
    endtask

    task automatic t_clear();
        t_evt(2'b01, 1'b1, 1'b0, 1'b1, "R5 borrow sets");
        wr(2'b00, 1'b1, 2'b01, 1'b1, 1'b0);
        check("R7 write 1 no effect", {7'd0, cpu_rdata[4]}, 8'd1);
        dma_clr = 1'b1;
        @(negedge clk);
        dma_clr = 1'b0;
        check("R7 dma_clr clears", {7'd0, cpu_rdata[4]}, 8'd0);
    endtask

    task automatic t_race();
        borrow_evt = 1'b1;
        dma_clr = 1'b1;
        @(negedge clk);
        borrow_evt = 1'b0;
        dma_clr = 1'b0;
        check("R8 set wins from idle", {7'd0, cpu_rdata[4]}, 8'd1);
        borrow_evt = 1'b1;
        dma_clr = 1'b1;
        @(negedge clk);
        borrow_evt = 1'b0;
        dma_clr = 1'b0;
        check("R8 set wins from pending", {7'd0, cpu_rdata[4]}, 8'd1);
        wr(2'b00, 1'b1, 2'b01, 1'b0, 1'b0);
    endtask

    task automatic t_rmw();
        cpu_rd_en = 1'b1;
        cpu_rmw = 1'b1;
        #1;
        check("R9 rmw reads 1", {7'd0, cpu_rdata[4]}, 8'd1);
        cpu_rmw = 1'b0;
        #1;
        check("R9 plain read shows 0", {7'd0, cpu_rdata[4]}, 8'd0);
        cpu_rd_en = 1'b0;
        @(negedge clk);
        check("R9 rmw left flag clear", {7'd0, irq_req}, 8'd0);
    endtask

    task automatic t_outputs();
        t_evt(2'b10, 1'b0, 1'b1, 1'b1, "R5 duty sets");
        dma_en = 1'b0;
        #1;
        check("R10 dma_req off", {7'd0, dma_req}, 8'd0);
        check("R10 irq_req on", {7'd0, irq_req}, 8'd1);
        dma_en = 1'b1;
        #1;
        check("R10 dma_req on", {7'd0, dma_req}, 8'd1);
        wr(2'b00, 1'b0, 2'b10, 1'b1, 1'b0);
        check("R10 irq masked", {7'd0, irq_req}, 8'd0);
        check("R10 flag kept", {7'd0, cpu_rdata[4]}, 8'd1);
        check("R10 dma still on", {7'd0, dma_req}, 8'd1);
        dma_en = 1'b0;
        wr(2'b00, 1'b0, 2'b00, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sw();
        t_edge(2'b01, 1'b1, 1'b1, "R2 rise/rise");
        t_edge(2'b01, 1'b0, 1'b0, "R2 rise/fall");
        t_edge(2'b10, 1'b1, 1'b0, "R3 fall/rise");
        t_edge(2'b10, 1'b0, 1'b1, "R3 fall/fall");
        t_edge(2'b11, 1'b1, 1'b1, "R3 both/rise");
        t_edge(2'b11, 1'b0, 1'b1, "R3 both/fall");
        t_edge(2'b00, 1'b1, 1'b0, "R3 off/rise");
        t_edge(2'b00, 1'b0, 1'b0, "R3 off/fall");
        t_evt(2'b01, 1'b0, 1'b1, 1'b0, "R5 src01 ignores duty");
        t_evt(2'b01, 1'b1, 1'b0, 1'b1, "R5 src01 borrow");
        t_evt(2'b10, 1'b1, 1'b0, 1'b0, "R5 src10 ignores borrow");
        t_evt(2'b10, 1'b0, 1'b1, 1'b1, "R5 src10 duty");
        t_evt(2'b11, 1'b1, 1'b0, 1'b1, "R5 src11 borrow");
        t_evt(2'b11, 1'b0, 1'b1, 1'b1, "R5 src11 duty");
        t_evt(2'b00, 1'b1, 1'b1, 1'b0, "R5 src00 ignores events");
        t_disabled();
        t_clear();
        t_race();
        t_rmw();
        t_outputs();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule